// File: doc/BRIEF.md
# Dual-Port RAM with Busy Arbitration

This block is a 2048-word by 8-bit memory with two independent ports, called left and right. Each port has its own address, enable, write strobe, write data and read data. Both ports can read and write at the same time. When both ports are enabled on the same address, an arbitration unit picks one owner and flags the other port as busy. A busy port cannot write, but it can still read.

A mode input selects one of two roles. In master mode the block arbitrates and drives the two busy outputs. In slave mode the block does no arbitration of its own. It keeps its busy outputs low and treats the two busy inputs as write inhibits. To build a wider word, several blocks share one address range: exactly one of them is the master, and its busy outputs feed the busy inputs of all the slaves. Every slice of the word then blocks the same port.

The model is synchronous and uses a single clock. Arbitration depends only on enables and addresses, so a read can make the other port busy. A port commits a write only after it has held the same address and enable for one full cycle. This gives the busy decision time to settle before any write can land.

Top module: `dual_port_busy_ram`

## Requirements
- R1: The memory has 2048 locations of 8 bits. Writes from both ports to different addresses in the same cycle both take effect.
- R2: Read data is registered. A port enabled with address A at clock edge k shows the stored word at A on its read data output after edge k. A port that is written at A in the same edge shows the old word.
- R3: A write is committed at edge k only if the port was also enabled with the same address at edge k-1. A write strobe held for a single edge stores nothing.
- R4: In master mode, if both ports become enabled on the same address at the same edge, the left port wins. The right busy output goes high after that edge and the left busy output stays low.
- R5: In master mode, if a port arrives at an address that the other port has already held for at least one edge, the new arrival loses and its busy output goes high after that edge.
- R6: The winner keeps ownership while its enable and address stay unchanged. The loser's busy output goes low after the edge at which the winner changes address or drops its enable.
- R7: A busy output is never high after an edge at which the two addresses differed or either enable was low.
- R8: In master mode, a port whose busy output is high commits no write.
- R9: In slave mode, both busy outputs stay low. A high busy input on a port blocks that port's writes and nothing else.
- R10: Busy never blocks reads. A busy port still returns the stored word with the latency of R2.
- R11: Arbitration ignores the write strobes. A read-only port can win and make the other port busy.
- R12: If both ports commit a write to the same address at the same edge, which can only happen in slave mode, the left port's data is stored.
- R13: During reset, both read data outputs and both busy outputs are zero.
- R14: At most one busy output is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | 1 = arbitrate and drive busy outputs; 0 = slave, busy inputs inhibit writes |
| l_en | input | 1 | Left port enable |
| l_wr | input | 1 | Left port write strobe (1 = write, 0 = read) |
| l_addr | input | 11 | Left port address |
| l_din | input | 8 | Left port write data |
| l_dout | output | 8 | Left port registered read data |
| l_busy_in | input | 1 | External write inhibit for the left port, used only in slave mode |
| l_busy_out | output | 1 | Left port busy flag, driven only in master mode |
| r_en | input | 1 | Right port enable |
| r_wr | input | 1 | Right port write strobe (1 = write, 0 = read) |
| r_addr | input | 11 | Right port address |
| r_din | input | 8 | Right port write data |
| r_dout | output | 8 | Right port registered read data |
| r_busy_in | input | 1 | External write inhibit for the right port, used only in slave mode |
| r_busy_out | output | 1 | Right port busy flag, driven only in master mode |

## Verification
The assertions assume that the enables and addresses are low and stable while reset is held. This matters because the settle check compares each committed write against the previous cycle's address and enable, and right after reset that previous cycle is a reset cycle. The assertions also assume that busy inputs carry meaning only in slave mode, and that the mode input changes only while both ports are idle. The stimulus keeps to these rules: it holds every port idle through reset, and it changes the mode only between scenarios. It changes inputs only on the falling clock edge and holds each address for at least two edges whenever a write is meant to land.

// File: rtl/dpr_arb_pkg.sv
package dpr_arb_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // Two ports contend when both are enabled on one address.
  function automatic logic clash_of(input logic en_a, input logic en_b,
                                    input logic same_addr);
    return en_a & en_b & same_addr;
  endfunction

  // The previous owner keeps the address while it stays put. Otherwise the
  // port that was already settled wins. A tie goes to the left port.
  function automatic owner_e pick_winner(input owner_e prev,
                                         input logic   l_settled,
                                         input logic   r_settled);
    if (prev == OWN_LEFT && l_settled)       return OWN_LEFT;
    else if (prev == OWN_RIGHT && r_settled) return OWN_RIGHT;
    else if (r_settled && !l_settled)        return OWN_RIGHT;
    else                                     return OWN_LEFT;
  endfunction

endpackage

// File: rtl/dpr_port_track.sv
module dpr_port_track #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] addr,
  output logic          settled
);

  logic          en_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= en;
      addr_q <= addr;
    end
  end

  // The port has held the same enabled address for one full cycle.
  assign settled = en & en_q & (addr == addr_q);

endmodule

// File: rtl/dpr_busy_arb.sv
module dpr_busy_arb
  import dpr_arb_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master,
  input  logic          l_en,
  input  logic [AW-1:0] l_addr,
  input  logic          l_settled,
  input  logic          r_en,
  input  logic [AW-1:0] r_addr,
  input  logic          r_settled,
  output logic [1:0]    busy_q
);

  owner_e owner_q;
  owner_e winner;
  logic   clash;

  assign clash  = clash_of(l_en, r_en, l_addr == r_addr);
  assign winner = pick_winner(owner_q, l_settled, r_settled);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q <= OWN_NONE;
      busy_q  <= 2'b00;
    end else begin
      owner_q   <= (master && clash) ? winner : OWN_NONE;
      busy_q[0] <= master & clash & (winner == OWN_RIGHT);
      busy_q[1] <= master & clash & (winner == OWN_LEFT);
    end
  end

endmodule

// File: rtl/dpr_mem_core.sv
module dpr_mem_core #(
  parameter int DEPTH = 2048,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            rd_en,
  input  logic [1:0]            wr_en,
  input  logic [1:0][AW-1:0]    addr,
  input  logic [1:0][DW-1:0]    wdata,
  output logic [1:0][DW-1:0]    rdata
);

  localparam int NPORT = 2;

  logic [DW-1:0] mem [DEPTH];

  // Port 0 (left) is written last, so it wins a same-address collision.
  always_ff @(posedge clk) begin
    if (wr_en[1]) mem[addr[1]] <= wdata[1];
    if (wr_en[0]) mem[addr[0]] <= wdata[0];
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    always_ff @(posedge clk) begin
      if (!rst_n)        rdata[p] <= '0;
      else if (rd_en[p]) rdata[p] <= mem[addr[p]];
    end
  end

endmodule

// File: rtl/dual_port_busy_ram.sv
module dual_port_busy_ram #(
  parameter int DEPTH = 2048,
  parameter int DW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     master_mode,
  input  logic                     l_en,
  input  logic                     l_wr,
  input  logic [$clog2(DEPTH)-1:0] l_addr,
  input  logic [DW-1:0]            l_din,
  output logic [DW-1:0]            l_dout,
  input  logic                     l_busy_in,
  output logic                     l_busy_out,
  input  logic                     r_en,
  input  logic                     r_wr,
  input  logic [$clog2(DEPTH)-1:0] r_addr,
  input  logic [DW-1:0]            r_din,
  output logic [DW-1:0]            r_dout,
  input  logic                     r_busy_in,
  output logic                     r_busy_out
);

  localparam int AW    = $clog2(DEPTH);
  localparam int NPORT = 2;

  logic [1:0]          en_v, wr_v, bin_v, settled, blk, fire, busy_q;
  logic [1:0][AW-1:0]  addr_v;
  logic [1:0][DW-1:0]  din_v, dout_v;
  logic                l_wr_fire, r_wr_fire;

  assign en_v   = {r_en, l_en};
  assign wr_v   = {r_wr, l_wr};
  assign bin_v  = {r_busy_in, l_busy_in};
  assign addr_v = {r_addr, l_addr};
  assign din_v  = {r_din, l_din};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpr_port_track #(.AW(AW)) u_trk (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en_v[p]),
      .addr    (addr_v[p]),
      .settled (settled[p])
    );
    // The inhibit comes from internal arbitration or from outside.
    assign blk[p]  = master_mode ? busy_q[p] : bin_v[p];
    assign fire[p] = en_v[p] & wr_v[p] & settled[p] & ~blk[p];
  end

  dpr_busy_arb #(.AW(AW)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .master    (master_mode),
    .l_en      (l_en),
    .l_addr    (l_addr),
    .l_settled (settled[0]),
    .r_en      (r_en),
    .r_addr    (r_addr),
    .r_settled (settled[1]),
    .busy_q    (busy_q)
  );

  dpr_mem_core #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_en (en_v),
    .wr_en (fire),
    .addr  (addr_v),
    .wdata (din_v),
    .rdata (dout_v)
  );

  assign l_wr_fire  = fire[0];
  assign r_wr_fire  = fire[1];
  assign l_dout     = dout_v[0];
  assign r_dout     = dout_v[1];
  assign l_busy_out = master_mode & busy_q[0];
  assign r_busy_out = master_mode & busy_q[1];

endmodule

// File: rtl/dual_port_busy_ram_chk.sv
module dual_port_busy_ram_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          master_mode,
  input logic          l_en,
  input logic [AW-1:0] l_addr,
  input logic          l_busy_in,
  input logic          l_busy_out,
  input logic          l_wr_fire,
  input logic          r_en,
  input logic [AW-1:0] r_addr,
  input logic          r_busy_in,
  input logic          r_busy_out,
  input logic          r_wr_fire
);

  // R14
  excl_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_busy_out && r_busy_out));

  // R7
  no_stray_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_en && r_en && (l_addr == r_addr)) |=> !l_busy_out && !r_busy_out);

  // R9
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> !l_busy_out && !r_busy_out);

  // R8
  l_busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && l_busy_out) |-> !l_wr_fire);

  // R8
  r_busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && r_busy_out) |-> !r_wr_fire);

  // R9
  l_ext_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && l_busy_in) |-> !l_wr_fire);

  // R9
  r_ext_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && r_busy_in) |-> !r_wr_fire);

  // R3
  l_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_wr_fire |-> $past(l_en) && (l_addr == $past(l_addr)));

  // R3
  r_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_wr_fire |-> $past(r_en) && (r_addr == $past(r_addr)));

endmodule

bind dual_port_busy_ram dual_port_busy_ram_chk #(.AW(AW)) u_chk (.*);

// File: tb/dual_port_busy_ram_test.sv
module dual_port_busy_ram_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        master_mode;
  logic        l_en, l_wr, l_busy_in, r_en, r_wr, r_busy_in;
  logic [10:0] l_addr, r_addr;
  logic [7:0]  l_din, r_din;
  logic [7:0]  l_dout, r_dout;
  logic        l_busy_out, r_busy_out;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_port_busy_ram uut (.*);

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive_l(input logic en, input logic wr, input logic [10:0] a, input logic [7:0] d);
    l_en = en; l_wr = wr; l_addr = a; l_din = d;
  endtask

  task automatic drive_r(input logic en, input logic wr, input logic [10:0] a, input logic [7:0] d);
    r_en = en; r_wr = wr; r_addr = a; r_din = d;
  endtask

  task automatic idle();
    drive_l(0, 0, '0, '0);
    drive_r(0, 0, '0, '0);
  endtask

  // A full write takes two edges on a held address.
  task automatic write_l(input logic [10:0] a, input logic [7:0] d);
    drive_l(1, 1, a, d); tick(); tick(); idle(); tick();
  endtask

  task automatic read_l(input logic [10:0] a, output logic [7:0] d);
    drive_l(1, 0, a, '0); tick(); d = l_dout; idle(); tick();
  endtask

  task automatic t_reset();
    chk("R13 l_dout", l_dout, 8'h00);
    chk("R13 r_dout", r_dout, 8'h00);
    chk("R13 busy", {6'b0, l_busy_out, r_busy_out}, 8'h00);
  endtask

  task automatic t_parallel();
    drive_l(1, 1, 11'd5, 8'h3C); drive_r(1, 1, 11'd6, 8'hC3);
    tick();
    chk("R7 distinct addr busy", {6'b0, l_busy_out, r_busy_out}, 8'h00);
    tick(); idle(); tick();
    drive_l(1, 0, 11'd6, '0); drive_r(1, 0, 11'd5, '0);
    tick();
    chk("R1 left reads right write", l_dout, 8'hC3);
    chk("R2 right reads left write", r_dout, 8'h3C);
    drive_l(1, 0, 11'd9, '0); drive_r(0, 0, 11'd9, '0);
    tick(); tick();
    chk("R7 one enable low busy", {6'b0, l_busy_out, r_busy_out}, 8'h00);
    idle(); tick();
  endtask

  task automatic t_settle();
    logic [7:0] d;
    write_l(11'd20, 8'h11);
    drive_l(1, 1, 11'd20, 8'h99); tick(); idle(); tick();
    read_l(11'd20, d);
    chk("R3 single edge write ignored", d, 8'h11);
  endtask

  task automatic t_same_cycle();
    logic [7:0] d;
    write_l(11'd40, 8'h00);
    drive_l(1, 1, 11'd40, 8'hAA); drive_r(1, 1, 11'd40, 8'h55);
    tick();
    chk("R4 right busy", {7'b0, r_busy_out}, 8'h01);
    chk("R4 left not busy", {7'b0, l_busy_out}, 8'h00);
    tick(); tick();
    chk("R6 right busy retained", {7'b0, r_busy_out}, 8'h01);
    idle(); tick();
    chk("R6 busy clears", {7'b0, r_busy_out}, 8'h00);
    read_l(11'd40, d);
    chk("R8 winner stored, loser blocked", d, 8'hAA);
  endtask

  task automatic t_read_contend();
    logic [7:0] d;
    write_l(11'd50, 8'h42);
    drive_l(1, 0, 11'd50, '0); drive_r(1, 1, 11'd50, 8'h13);
    tick();
    chk("R11 reading left makes right busy", {7'b0, r_busy_out}, 8'h01);
    tick();
    chk("R10 busy right still reads", r_dout, 8'h42);
    tick(); idle(); tick();
    read_l(11'd50, d);
    chk("R8 busy right write blocked", d, 8'h42);
  endtask

  task automatic t_late();
    logic [7:0] d;
    write_l(11'd60, 8'h10);
    drive_r(1, 0, 11'd60, '0); tick();
    drive_l(1, 1, 11'd60, 8'h77); tick();
    chk("R5 late left busy", {7'b0, l_busy_out}, 8'h01);
    chk("R5 early right free", {7'b0, r_busy_out}, 8'h00);
    tick();
    chk("R10 busy left still reads", l_dout, 8'h10);
    drive_r(0, 0, 11'd60, '0); tick();
    chk("R6 left busy clears after winner leaves", {7'b0, l_busy_out}, 8'h00);
    tick(); idle(); tick();
    read_l(11'd60, d);
    chk("R6 left write lands once free", d, 8'h77);
  endtask

  task automatic t_slave();
    logic [7:0] d;
    master_mode = 1'b0; tick();
    write_l(11'd80, 8'h01);
    drive_l(1, 0, 11'd70, '0); drive_r(1, 0, 11'd70, '0);
    l_busy_in = 1'b1;
    tick(); tick();
    chk("R9 slave no busy out", {6'b0, l_busy_out, r_busy_out}, 8'h00);
    idle();
    drive_l(1, 1, 11'd80, 8'h5A); drive_r(1, 1, 11'd81, 8'hA5);
    tick(); tick(); idle(); l_busy_in = 1'b0; tick();
    read_l(11'd80, d);
    chk("R9 inhibited left write", d, 8'h01);
    read_l(11'd81, d);
    chk("R9 free right write", d, 8'hA5);
    drive_l(1, 1, 11'd90, 8'hE1); drive_r(1, 1, 11'd90, 8'h1E);
    tick(); tick(); idle(); tick();
    read_l(11'd90, d);
    chk("R12 left data wins", d, 8'hE1);
    master_mode = 1'b1; tick();
  endtask

  initial begin
    master_mode = 1'b1; l_busy_in = 1'b0; r_busy_in = 1'b0;
    idle();
    rst_n = 1'b0;
    repeat (3) tick();
    t_reset();
    rst_n = 1'b1; tick();
    t_parallel();
    t_settle();
    t_same_cycle();
    t_read_contend();
    t_late();
    t_slave();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule